// File: doc/BRIEF.md
# Power-Guarded Byte-Wide Static Memory Port

This block is a clocked model of a byte-wide static memory that is driven through the usual active-low chip select, output enable and write enable pins. The address bus is 17 bits wide. A fast system clock samples the pins. Read and write cycles are then decoded from the sampled levels. A write is framed by the overlap of chip select and write enable: it opens when the later of the two falls and closes when the first of the two rises. The byte is committed when the overlap closes.

The block drives a read-data bus together with a separate data-valid enable, so that a tristate driver can be built outside the block. Supply status arrives as two digital comparator flags: a fail flag and an in-tolerance flag. Whenever the supply is not good, every pin is ignored, writes are blocked and the enable is released. The storage depth is a parameter, which lets simulation use a small array. Address bits above the stored range alias. A parameterised write-enable recovery time guards against writes that follow one another too closely.

Top module: `gsram_port`

## Requirements
- R1: While reset is held and after it is released with all pins idle, `data_oe` is 0 and `rdata` is all zeros.
- R2: When chip select and output enable are sampled low and write enable is sampled high while the supply is good, `data_oe` is 1 and `rdata` holds the byte stored at that address. Both appear two clock edges after the edge that samples the pins.
- R3: `data_oe` is 0 two edges after any sample in which write enable is low, chip select is high or output enable is high. This includes a write enable that falls during an ongoing read. `rdata` reads zero whenever `data_oe` is 0.
- R4: A write commits at the first sample in which chip select and write enable are no longer both low. This holds whether write enable (write-enable-controlled) or chip select (chip-select-controlled) frames the cycle.
- R5: The committed byte and address are those present at the last sample in which the overlap was still active. The data at the closing sample is not used.
- R6: After an overlap closes, write enable must be sampled high on at least REC_CLKS further clocks before a new overlap is accepted. An overlap that opens earlier stores nothing. An overlap that opens exactly at that count is accepted.
- R7: While `vcc_fail` is sampled high, `data_oe` is 0 and no write commits. An overlap that was open when the supply failed stores nothing, even if the supply recovers before the overlap closes.
- R8: After reset or a failure, the supply is good only from the first sample of `vcc_good` high with `vcc_fail` low. While neither flag is set, the port stays protected and `data_oe` stays 0.
- R9: A read sampled at the same edge as a commit to the same address returns the newly written byte.
- R10: Only the low log2(DEPTH) address bits select a byte. Addresses that differ only in higher bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W (17) | Byte address |
| wdata | input | DATA_W (8) | Write data |
| vcc_fail | input | 1 | Supply below write-protect threshold |
| vcc_good | input | 1 | Supply above upper operating threshold |
| rdata | output | DATA_W (8) | Read data, zero when not driving |
| data_oe | output | 1 | High while `rdata` should drive the external bus |

## Verification
Writes are applied in two forms. In one, write enable frames the overlap. In the other, chip select frames it. Each form is followed by reads of the same byte, which shows that both edges of the overlap are decoded. A write whose data changes on every cycle tells the last-overlap-sample rule apart from capture at the first or the closing sample. Back-to-back writes at one and at two recovery samples locate the acceptance boundary. A read held through a write enable pulse separates output release from the same-edge bypass. Supply sequences fail in the middle of a write, pass through the band where neither flag is set, and then restore the supply. These show that protection holds until the in-tolerance flag returns and that the interrupted byte keeps its old value. An aliased write and read confirm address folding.

// File: rtl/gsram_pkg.sv
`timescale 1ns/1ps
package gsram_pkg;

  // sampled control levels, all as seen on the pins
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic vcc_fail;
    logic vcc_good;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                vcc_fail: 1'b1, vcc_good: 1'b0};

endpackage

// File: rtl/gsram_pin_sampler.sv
`timescale 1ns/1ps
module gsram_pin_sampler
  import gsram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl_pin,
  input  logic [ADDR_W-1:0] addr_pin,
  input  logic [DATA_W-1:0] data_pin,
  output ctl_t              ctl_s,
  output logic [IDX_W-1:0]  idx_s,
  output logic [DATA_W-1:0] data_s
);

  ctl_t              ctl_d;
  logic [IDX_W-1:0]  idx_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    ctl_d  = ctl_pin;
    idx_d  = addr_pin[IDX_W-1:0];
    data_d = data_pin;
  end

  // upper address bits fold onto the stored range
  generate
    if (ADDR_W > IDX_W) begin : g_fold
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr_pin[ADDR_W-1:IDX_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s  <= CTL_IDLE;
      idx_s  <= '0;
      data_s <= '0;
    end else begin
      ctl_s  <= ctl_d;
      idx_s  <= idx_d;
      data_s <= data_d;
    end
  end

endmodule

// File: rtl/gsram_supply_gate.sv
`timescale 1ns/1ps
module gsram_supply_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_s,
  input  logic good_s,
  output logic pwr_now
);

  logic pwr_q;

  // fail wins; good restores; otherwise keep the last verdict
  always_comb begin
    if (fail_s)      pwr_now = 1'b0;
    else if (good_s) pwr_now = 1'b1;
    else             pwr_now = pwr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= 1'b0;
    else        pwr_q <= pwr_now;
  end

  assert_neutral_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fail_s && !good_s) |-> (pwr_now == pwr_q));

endmodule

// File: rtl/gsram_write_framer.sv
`timescale 1ns/1ps
module gsram_write_framer #(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 10,
  parameter int REC_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_s,
  input  logic              we_n_s,
  input  logic [IDX_W-1:0]  idx_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              pwr_now,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data
);

  localparam int CNT_W = $clog2(REC_CLKS + 2);
  localparam logic [CNT_W-1:0] REC_MAX = CNT_W'(REC_CLKS);

  logic             ov_now, ov_q, ov_start, ov_end;
  logic             ok_q, ok_d;
  logic             rec_ok;
  logic [CNT_W-1:0] rec_q, rec_d;
  logic             hold_en;

  assign ov_now   = !ce_n_s && !we_n_s;
  assign ov_start = ov_now && !ov_q;
  assign ov_end   = ov_q && !ov_now;
  assign rec_ok   = (rec_q == REC_MAX);
  assign hold_en  = ov_now;

  always_comb begin
    if (ov_start)    ok_d = rec_ok && pwr_now;
    else if (ov_now) ok_d = ok_q && pwr_now;
    else             ok_d = 1'b0;
  end

  always_comb begin
    rec_d = rec_q;
    if (ov_end)                      rec_d = '0;
    else if (we_n_s && !rec_ok)      rec_d = rec_q + 1'b1;
  end

  assign commit = ov_end && ok_q && pwr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      ok_q  <= 1'b0;
      rec_q <= REC_MAX;
    end else begin
      ov_q  <= ov_now;
      ok_q  <= ok_d;
      rec_q <= rec_d;
    end
  end

  // last overlap sample is what gets written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_idx  <= '0;
      commit_data <= '0;
    end else if (hold_en) begin
      commit_idx  <= idx_s;
      commit_data <= data_s;
    end
  end

  assert_rec_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q <= REC_MAX);

  assert_early_overlap_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_start && !rec_ok) |=> !ok_q);

  assert_commit_closes_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (ce_n_s || we_n_s));

endmodule

// File: rtl/gsram_store.sv
`timescale 1ns/1ps
module gsram_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              commit,
  input  logic [IDX_W-1:0]  commit_idx,
  input  logic [DATA_W-1:0] commit_data,
  output logic [DATA_W-1:0] rdata,
  output logic              data_oe
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              bypass;
  logic [DATA_W-1:0] rdata_d;

  assign bypass = commit && (commit_idx == rd_idx);

  always_comb begin
    if (!rd_req)     rdata_d = '0;
    else if (bypass) rdata_d = commit_data;
    else             rdata_d = mem[rd_idx];
  end

  // array carries no reset
  always_ff @(posedge clk) begin
    if (commit) mem[commit_idx] <= commit_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_oe <= 1'b0;
      rdata   <= '0;
    end else begin
      data_oe <= rd_req;
      rdata   <= rdata_d;
    end
  end

  assert_idle_bus_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (rdata == '0));

endmodule

// File: rtl/gsram_port.sv
`timescale 1ns/1ps
module gsram_port
  import gsram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 1024,
  parameter int REC_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vcc_fail,
  input  logic              vcc_good,
  output logic [DATA_W-1:0] rdata,
  output logic              data_oe
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  ctl_t              ctl_pin, ctl_s;
  logic [IDX_W-1:0]  idx_s, commit_idx;
  logic [DATA_W-1:0] data_s, commit_data;
  logic              pwr_now, commit, rd_req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  always_comb begin
    ctl_pin.ce_n     = chip_sel_n;
    ctl_pin.oe_n     = out_en_n;
    ctl_pin.we_n     = wr_en_n;
    ctl_pin.vcc_fail = vcc_fail;
    ctl_pin.vcc_good = vcc_good;
  end

  gsram_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_sampler (
    .clk(clk), .rst_n(rst_i_n), .ctl_pin(ctl_pin), .addr_pin(addr),
    .data_pin(wdata), .ctl_s(ctl_s), .idx_s(idx_s), .data_s(data_s)
  );

  gsram_supply_gate u_supply (
    .clk(clk), .rst_n(rst_i_n), .fail_s(ctl_s.vcc_fail),
    .good_s(ctl_s.vcc_good), .pwr_now(pwr_now)
  );

  gsram_write_framer #(.DATA_W(DATA_W), .IDX_W(IDX_W), .REC_CLKS(REC_CLKS)) u_framer (
    .clk(clk), .rst_n(rst_i_n), .ce_n_s(ctl_s.ce_n), .we_n_s(ctl_s.we_n),
    .idx_s(idx_s), .data_s(data_s), .pwr_now(pwr_now), .commit(commit),
    .commit_idx(commit_idx), .commit_data(commit_data)
  );

  assign rd_req = pwr_now && !ctl_s.ce_n && !ctl_s.oe_n && ctl_s.we_n;

  gsram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_i_n), .rd_req(rd_req), .rd_idx(idx_s),
    .commit(commit), .commit_idx(commit_idx), .commit_data(commit_data),
    .rdata(rdata), .data_oe(data_oe)
  );

  assert_we_fall_releases_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ctl_s.we_n |=> !data_oe);

  assert_fail_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    ctl_s.vcc_fail |-> !commit);

  assert_fail_releases_bus_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    ctl_s.vcc_fail |=> !data_oe);

  assert_drive_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    data_oe |-> $past(!ctl_s.ce_n && !ctl_s.oe_n && pwr_now));

endmodule

// File: tb/gsram_port_bench.sv
`timescale 1ns/1ps
module gsram_port_bench;

  localparam int DEPTH = 1024;
  localparam int REC   = 2;

  typedef struct {
    int unsigned at;
    logic        oe;
    logic [7:0]  dat;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chip_sel_n, out_en_n, wr_en_n, vcc_fail, vcc_good;
  logic [16:0] addr;
  logic [7:0]  wdata, rdata;
  logic        data_oe;
  logic        f_fail, f_good;
  logic [7:0]  model [DEPTH];
  exp_t        q[$];
  int unsigned cyc = 0;
  int          n_vec = 0;
  int          n_bad = 0;

  gsram_port #(.DEPTH(DEPTH), .REC_CLKS(REC)) u_gsram_port (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata), .vcc_fail(vcc_fail),
    .vcc_good(vcc_good), .rdata(rdata), .data_oe(data_oe)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor: pops items due this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (data_oe !== e.oe || rdata !== (e.oe ? e.dat : 8'h00)) begin
        n_bad++;
        $display("FAIL %s: oe=%b data=%h, expected oe=%b data=%h", e.tag,
                 data_oe, rdata, e.oe, e.oe ? e.dat : 8'h00);
      end
    end
  end

  task automatic step(input logic c, input logic o, input logic w,
                      input logic [16:0] a, input logic [7:0] d,
                      input logic eoe, input logic [7:0] ed, input string tag);
    @(posedge clk); #1;
    chip_sel_n = c; out_en_n = o; wr_en_n = w; addr = a; wdata = d;
    vcc_fail = f_fail; vcc_good = f_good;
    q.push_back('{cyc + 2, eoe, ed, tag});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 1, 1, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input logic [16:0] a, input string tag);
    step(0, 0, 1, a, 0, 1, model[a % DEPTH], tag);
  endtask

  // write framed by write enable; ends with one idle sample
  task automatic wr_we(input logic [16:0] a, input logic [7:0] d, input string tag);
    step(0, 1, 1, a, d, 0, 0, tag);
    step(0, 1, 0, a, d, 0, 0, tag);
    step(0, 1, 0, a, d, 0, 0, tag);
    step(0, 1, 1, a, d, 0, 0, tag);
    step(1, 1, 1, 0, 0, 0, 0, tag);
  endtask

  // write framed by chip select
  task automatic wr_ce(input logic [16:0] a, input logic [7:0] d, input string tag);
    step(1, 1, 0, a, d, 0, 0, tag);
    step(0, 1, 0, a, d, 0, 0, tag);
    step(0, 1, 0, a, d, 0, 0, tag);
    step(1, 1, 0, a, d, 0, 0, tag);
    step(1, 1, 1, 0, 0, 0, 0, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; f_fail = 1'b0; f_good = 1'b0;
    chip_sel_n = 1; out_en_n = 1; wr_en_n = 1; addr = 0; wdata = 0;
    vcc_fail = 0; vcc_good = 0;
    repeat (3) @(posedge clk);
    #5;
    n_vec++;
    if (data_oe !== 1'b0 || rdata !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: oe=%b data=%h, expected oe=0 data=00", data_oe, rdata);
    end
    rst_n = 1'b1;
    idle(4, "R1");
    // neither flag yet: still protected
    step(0, 0, 1, 17'd10, 0, 0, 0, "R8");
    step(0, 0, 1, 17'd10, 0, 0, 0, "R8");
    f_good = 1'b1;
    idle(3, "R1");

    // R4 write-enable framed writes, R2 reads
    wr_we(17'd10, 8'hA1, "R4"); model[10] = 8'hA1; idle(3, "R4");
    wr_we(17'd11, 8'h11, "R4"); model[11] = 8'h11; idle(3, "R4");
    wr_we(17'd30, 8'h30, "R4"); model[30] = 8'h30; idle(3, "R4");
    wr_we(17'd31, 8'h31, "R4"); model[31] = 8'h31; idle(3, "R4");
    wr_we(17'd20, 8'h20, "R4"); model[20] = 8'h20; idle(3, "R4");
    rd(17'd10, "R2"); rd(17'd11, "R2"); rd(17'd30, "R2"); rd(17'd31, "R2");
    // R4 chip-select framed write
    idle(3, "R4");
    wr_ce(17'd40, 8'h4C, "R4"); model[40] = 8'h4C; idle(3, "R4");
    rd(17'd40, "R4");
    // R3 chip select high or output enable high: no drive
    step(1, 0, 1, 17'd40, 0, 0, 0, "R3");
    step(0, 1, 1, 17'd40, 0, 0, 0, "R3");

    // R5 data changes during overlap; closing sample data ignored
    idle(3, "R5");
    step(0, 1, 1, 17'd50, 8'h00, 0, 0, "R5");
    step(0, 1, 0, 17'd50, 8'h01, 0, 0, "R5");
    step(0, 1, 0, 17'd50, 8'h02, 0, 0, "R5");
    step(0, 1, 0, 17'd50, 8'h03, 0, 0, "R5");
    step(0, 1, 1, 17'd50, 8'hFF, 0, 0, "R5");
    model[50] = 8'h03;
    idle(2, "R5");
    rd(17'd50, "R5");

    // R6 recovery: one WE-high sample after close -> rejected
    idle(3, "R6");
    wr_we(17'd10, 8'hB2, "R6"); model[10] = 8'hB2;
    step(0, 1, 0, 17'd11, 8'hEE, 0, 0, "R6");
    step(0, 1, 0, 17'd11, 8'hEE, 0, 0, "R6");
    step(0, 1, 1, 17'd11, 8'hEE, 0, 0, "R6");
    idle(3, "R6");
    rd(17'd11, "R6"); rd(17'd10, "R6");
    // exactly REC samples -> accepted
    idle(3, "R6");
    wr_we(17'd10, 8'hC3, "R6"); model[10] = 8'hC3;
    idle(1, "R6");
    step(0, 1, 0, 17'd11, 8'h5A, 0, 0, "R6");
    step(0, 1, 1, 17'd11, 8'h5A, 0, 0, "R6");
    model[11] = 8'h5A;
    idle(3, "R6");
    rd(17'd11, "R6"); rd(17'd10, "R6");

    // R3 write enable falls during read; R9 same-edge bypass
    idle(3, "R3");
    rd(17'd20, "R3"); rd(17'd20, "R3");
    step(0, 0, 0, 17'd20, 8'h5C, 0, 0, "R3");
    step(0, 0, 0, 17'd20, 8'h5C, 0, 0, "R3");
    step(0, 0, 1, 17'd20, 8'h77, 1, 8'h5C, "R9");
    model[20] = 8'h5C;
    rd(17'd20, "R9");

    // R7 supply fails in the middle of a write
    idle(3, "R7");
    step(0, 1, 1, 17'd30, 8'hEE, 0, 0, "R7");
    step(0, 1, 0, 17'd30, 8'hEE, 0, 0, "R7");
    f_fail = 1'b1; f_good = 1'b0;
    step(0, 1, 0, 17'd30, 8'hEE, 0, 0, "R7");
    step(0, 0, 1, 17'd31, 8'h00, 0, 0, "R7");
    f_fail = 1'b0;
    step(0, 1, 0, 17'd30, 8'hEE, 0, 0, "R8");
    step(0, 1, 1, 17'd30, 8'hEE, 0, 0, "R8");
    step(0, 0, 1, 17'd30, 8'h00, 0, 0, "R8");
    step(0, 0, 1, 17'd31, 8'h00, 0, 0, "R8");
    f_good = 1'b1;
    rd(17'd30, "R7");
    // a full write while failed is ignored
    idle(3, "R7");
    f_fail = 1'b1; f_good = 1'b0;
    wr_we(17'd31, 8'h99, "R7");
    step(0, 0, 1, 17'd31, 8'h00, 0, 0, "R7");
    f_fail = 1'b0; f_good = 1'b1;
    idle(3, "R7");
    rd(17'd31, "R7");

    // R10 address folding
    idle(3, "R10");
    wr_we(17'h00405, 8'hC5, "R10"); model[5] = 8'hC5;
    idle(2, "R10");
    rd(17'd5, "R10"); rd(17'h1FC05, "R10");

    idle(4, "R1");
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    summary();
  end

endmodule